// File: doc/BRIEF.md
# Additive lagged random word generator

This block produces a stream of pseudo-random words, 36 bits wide by default. It keeps an accumulator and a small table of registers, eight entries by default. A down-counting index picks one table entry for each step. An accepted step adds the picked entry to the accumulator, modulo 2^WIDTH. The sum goes back into both the accumulator and that entry, and it is presented on the output for one cycle with a valid pulse.

The index starts at the top entry and counts down through zero to a distinct "spent" state. The step taken from the spent state uses the top entry again and reloads the index with the second-highest entry. From there the walk down repeats.

Three other strobes act on the whole state. The first reseeds everything. The second takes a snapshot of the accumulator, the index and every table entry into shadow registers. The third copies the snapshot back, so that a run of words can be replayed exactly. This lets a test source regenerate the data it wrote earlier, so that it can compare against it.

Top module: `lagrng`

## Requirements
- R1: After reset, valid_o is 0 and word_o is 0. The live state equals the seeded state of R2, and the shadow snapshot holds that same seeded state.
- R2: An init_i strobe overrides every other strobe in its cycle. It reloads entry k with the octal value 7654321 rotated left by 3*k bits within WIDTH. With WIDTH 36 this gives entry 7 = 543210000076 and entry 6 = 654321000007 (octal). It loads the accumulator with the top entry's seed and sets the index to DEPTH-1. The first step after init therefore outputs 2*seed[7] mod 2^36 = 306420000174 (octal).
- R3: A step taken when the index is between 0 and DEPTH-1 computes sum = accumulator + entry[index]. It writes sum to both the accumulator and entry[index], and then the index decrements by one.
- R4: A step taken from the spent state (the state after index 0 has been used) uses entry DEPTH-1 in the same way. The index then becomes DEPTH-2.
- R5: A save_i strobe copies the accumulator, the index and all table entries into the shadow. It does not change the live state or word_o, and valid_o stays 0.
- R6: A restore_i strobe copies the shadow back into the live state. The words after it repeat the words that followed the matching save. When save_i and restore_i arrive in the same cycle, the restore wins and the shadow is unchanged.
- R7: A next_i strobe in the same cycle as init_i, save_i or restore_i is ignored: no step happens and valid_o stays 0 in the following cycle.
- R8: Each accepted step sets valid_o to 1 for exactly one cycle, starting in the cycle after the strobe, with word_o equal to the new sum. word_o holds its value until the next accepted step.
- R9: Addition is modulo 2^WIDTH and the carry out is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Reseed strobe |
| next_i | input | 1 | Step request strobe |
| save_i | input | 1 | Snapshot strobe |
| restore_i | input | 1 | Replay strobe |
| word_o | output | WIDTH | Most recent sum |
| valid_o | output | 1 | One-cycle pulse after an accepted step |

## Verification
The hardest situation to reach from the ports is a snapshot taken while the index is in its spent state. A replay from there has to redo the reload of the index with the second-highest entry. The stimulus gets there by issuing exactly DEPTH steps after an init, then a save, and later a restore. The words that follow are compared with the recorded words. Strobe collisions, and a save combined with a restore, are driven explicitly. A cycle-accurate behavioural model checks word_o and valid_o on every clock.

// File: rtl/lagrng_pkg.sv
package lagrng_pkg;

   // Seed for table entry k: base pattern rotated left by 3*k inside width bits.
   function automatic logic [63:0] seed_word(int unsigned k, int unsigned width);
      logic [63:0] base;
      logic [63:0] mask;
      logic [63:0] rot;
      int unsigned sh;
      base = 64'o7654321;
      mask = (width >= 64) ? {64{1'b1}} : ((64'd1 << width) - 64'd1);
      sh   = (3 * k) % width;
      if (sh == 0)
         rot = base;
      else
         rot = (base << sh) | (base >> (width - sh));
      return rot & mask;
   endfunction

endpackage

// File: rtl/lagrng_index.sv
module lagrng_index #(
   parameter int DEPTH = 8,
   localparam int SW = $clog2(DEPTH),
   localparam int IW = SW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_i,
   input  logic          save_i,
   input  logic          restore_i,
   input  logic          step_i,
   output logic [SW-1:0] sel_o,
   output logic          spent_o
);
   localparam logic [IW-1:0] TOP_IDX  = IW'(DEPTH - 1);
   localparam logic [IW-1:0] NEXT_IDX = IW'(DEPTH - 2);

   logic [IW-1:0] idx_q;
   logic [IW-1:0] shd_q;

   assign spent_o = idx_q[IW-1];
   assign sel_o   = spent_o ? SW'(DEPTH - 1) : idx_q[SW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= TOP_IDX;
         shd_q <= TOP_IDX;
      end else if (init_i) begin
         idx_q <= TOP_IDX;
      end else if (restore_i) begin
         idx_q <= shd_q;
      end else if (save_i) begin
         shd_q <= idx_q;
      end else if (step_i) begin
         idx_q <= spent_o ? NEXT_IDX : idx_q - IW'(1);
      end
   end

   // the only negative value is all ones
   p_spent_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spent_o |-> (idx_q == {IW{1'b1}}));
   p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !spent_o |-> (idx_q <= TOP_IDX));
   p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && spent_o && !init_i && !restore_i && !save_i) |=> (sel_o == SW'(DEPTH - 2)));
endmodule

// File: rtl/lagrng_store.sv
module lagrng_store
   import lagrng_pkg::*;
#(
   parameter int WIDTH = 36,
   parameter int DEPTH = 8,
   localparam int SW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             save_i,
   input  logic             restore_i,
   input  logic             step_i,
   input  logic [SW-1:0]    sel_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] rdata_o
);
   logic [DEPTH-1:0][WIDTH-1:0] tab_w;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam logic [63:0] S64 = seed_word(e, WIDTH);
      localparam logic [WIDTH-1:0] SEED = S64[WIDTH-1:0];
      logic [WIDTH-1:0] ent_q;
      logic [WIDTH-1:0] shd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= SEED;
            shd_q <= SEED;
         end else if (init_i) begin
            ent_q <= SEED;
         end else if (restore_i) begin
            ent_q <= shd_q;
         end else if (save_i) begin
            shd_q <= ent_q;
         end else if (step_i && (sel_i == SW'(e))) begin
            ent_q <= wdata_i;
         end
      end
      assign tab_w[e] = ent_q;
   end

   assign rdata_o = tab_w[sel_i];

   p_write_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !init_i && !restore_i && !save_i) |=> (tab_w[$past(sel_i)] == $past(wdata_i)));
   p_table_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !init_i && !restore_i) |=> $stable(tab_w));
endmodule

// File: rtl/lagrng.sv
module lagrng
   import lagrng_pkg::*;
#(
   parameter int WIDTH = 36,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             next_i,
   input  logic             save_i,
   input  logic             restore_i,
   output logic [WIDTH-1:0] word_o,
   output logic             valid_o
);
   localparam int SW = $clog2(DEPTH);
   localparam logic [63:0] TOP64 = seed_word(DEPTH - 1, WIDTH);
   localparam logic [WIDTH-1:0] TOP_SEED = TOP64[WIDTH-1:0];

   if (WIDTH < 24 || WIDTH > 64) begin : g_bad_width
      $error("lagrng: WIDTH must lie in 24..64");
   end
   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("lagrng: DEPTH must lie in 2..64");
   end

   // strobe decode: init > restore > save > step
   logic do_init, do_rest, do_save, do_step;
   assign do_init = init_i;
   assign do_rest = !init_i && restore_i;
   assign do_save = !init_i && !restore_i && save_i;
   assign do_step = !init_i && !restore_i && !save_i && next_i;

   logic [SW-1:0]    sel;
   logic             spent;
   logic [WIDTH-1:0] rdata;
   logic [WIDTH-1:0] sum;
   logic [WIDTH-1:0] acc_q, acc_shd_q, word_q;
   logic             valid_q;

   lagrng_index #(.DEPTH(DEPTH)) u_index (
      .clk(clk), .rst_n(rst_n),
      .init_i(do_init), .save_i(do_save), .restore_i(do_rest), .step_i(do_step),
      .sel_o(sel), .spent_o(spent)
   );

   lagrng_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .init_i(do_init), .save_i(do_save), .restore_i(do_rest), .step_i(do_step),
      .sel_i(sel), .wdata_i(sum), .rdata_o(rdata)
   );

   assign sum = acc_q + rdata;   // carry out dropped

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= TOP_SEED;
         acc_shd_q <= TOP_SEED;
      end else if (do_init) begin
         acc_q <= TOP_SEED;
      end else if (do_rest) begin
         acc_q <= acc_shd_q;
      end else if (do_save) begin
         acc_shd_q <= acc_q;
      end else if (do_step) begin
         acc_q <= sum;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= do_step;
         if (do_step) word_q <= sum;
      end
   end

   assign word_o  = word_q;
   assign valid_o = valid_q;

   p_word_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (word_o == acc_q));
   p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (next_i && (init_i || save_i || restore_i)) |=> !valid_o);
   p_init_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (acc_q == TOP_SEED && sel == SW'(DEPTH - 1) && !spent));
   p_mod_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (word_o == WIDTH'($past(acc_q) + $past(rdata))));
   p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(word_o));
   p_save_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && !init_i && !restore_i) |=> ($stable(acc_q) && !valid_o));
endmodule

// File: tb/tb_lagrng.sv
module tb_lagrng;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_i = 1'b0, next_i = 1'b0, save_i = 1'b0, restore_i = 1'b0;
   logic [35:0] word_o;
   logic        valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lagrng dut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
      .save_i(save_i), .restore_i(restore_i), .word_o(word_o), .valid_o(valid_o)
   );

   // reference state
   logic [35:0] m_tab [8];
   logic [35:0] m_shd [8];
   logic [35:0] m_acc, m_sacc, e_word;
   int          m_idx, m_sidx;
   bit          e_valid;
   logic [35:0] rec_q[$];

   function automatic logic [35:0] seed_of(int k);
      case (k)
         0: return 36'o7654321;
         1: return 36'o76543210;
         2: return 36'o765432100;
         3: return 36'o7654321000;
         4: return 36'o76543210000;
         5: return 36'o765432100000;
         6: return 36'o654321000007;
         default: return 36'o543210000076;
      endcase
   endfunction

   task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%o expected=%o", tag, act, exp);
      end
   endtask

   task automatic model_seed();
      for (int k = 0; k < 8; k++) m_tab[k] = seed_of(k);
      m_acc = seed_of(7);
      m_idx = 7;
   endtask

   // drive one cycle from a negedge, update model at the edge, compare at the next negedge
   task automatic tick(bit n, bit i, bit s, bit r, string tag);
      int j;
      logic [35:0] sum;
      init_i = i; next_i = n; save_i = s; restore_i = r;
      @(posedge clk);
      e_valid = 1'b0;
      if (i) model_seed();
      else if (r) begin
         for (int k = 0; k < 8; k++) m_tab[k] = m_shd[k];
         m_acc = m_sacc; m_idx = m_sidx;
      end else if (s) begin
         for (int k = 0; k < 8; k++) m_shd[k] = m_tab[k];
         m_sacc = m_acc; m_sidx = m_idx;
      end else if (n) begin
         j = (m_idx < 0) ? 7 : m_idx;
         sum = m_acc + m_tab[j];
         m_acc = sum; m_tab[j] = sum;
         m_idx = (m_idx < 0) ? 6 : m_idx - 1;
         e_word = sum; e_valid = 1'b1;
      end
      @(negedge clk);
      init_i = 1'b0; next_i = 1'b0; save_i = 1'b0; restore_i = 1'b0;
      chk(valid_o == e_valid, {tag, " valid"}, {35'd0, valid_o}, {35'd0, e_valid});
      chk(word_o == e_word, {tag, " word"}, word_o, e_word);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_seed();
      for (int k = 0; k < 8; k++) m_shd[k] = seed_of(k);
      m_sacc = seed_of(7); m_sidx = 7;
      e_word = '0; e_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(valid_o == 1'b0, "R1 reset valid", {35'd0, valid_o}, 36'd0);
      chk(word_o == 36'd0, "R1 reset word", word_o, 36'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // first step from reset seeds: 2*seed7 with carry dropped
      tick(1, 0, 0, 0, "R1 first step");
      chk(word_o == 36'o306420000174, "R9 carry dropped", word_o, 36'o306420000174);
      for (int n = 0; n < 20; n++) tick(1, 0, 0, 0, "R3 walk");
      // gaps: word holds
      tick(0, 0, 0, 0, "R8 hold");
      tick(0, 0, 0, 0, "R8 hold");

      // init mid-run
      tick(1, 0, 0, 0, "R3 pre-init");
      tick(0, 1, 0, 0, "R2 init");
      tick(1, 0, 0, 0, "R2 after init");
      chk(word_o == 36'o306420000174, "R2 first word", word_o, 36'o306420000174);

      // reach the spent state: 7 more steps (indices 6..0), then save
      for (int n = 0; n < 7; n++) tick(1, 0, 0, 0, "R3 descend");
      tick(0, 0, 1, 0, "R5 save at spent");
      rec_q.delete();
      for (int n = 0; n < 12; n++) begin
         tick(1, 0, 0, 0, "R4 wrap step");
         rec_q.push_back(word_o);
      end
      tick(0, 0, 0, 1, "R6 restore");
      for (int n = 0; n < 12; n++) begin
         tick(1, 0, 0, 0, "R6 replay");
         chk(word_o == rec_q[n], "R6 replay match", word_o, rec_q[n]);
      end

      // collisions
      tick(1, 0, 1, 0, "R7 next+save");
      tick(1, 0, 0, 1, "R7 next+restore");
      tick(1, 1, 0, 0, "R7 next+init");
      tick(1, 0, 0, 0, "R7 after init");
      tick(1, 0, 0, 0, "R3 step");
      tick(0, 0, 1, 1, "R6 save+restore");
      tick(0, 0, 0, 1, "R6 restore again");
      tick(1, 0, 0, 0, "R6 after double");
      tick(1, 1, 1, 1, "R2 all strobes");

      // long mixed run across many wraps
      for (int n = 0; n < 300; n++) begin
         tick((n % 5) != 3, 0, (n % 37) == 11, (n % 53) == 40, "R4 long run");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule